// File: doc/BRIEF.md
# Multi-Channel Marker Deskew Unit

This block lines up to six parallel data channels. Each channel carries a marker flag that pulses once per marker period. A membership mask picks the channels that form the deskew set. A single-lane mode cuts that set down to channels 0 and 4, where channel 4 carries the timestamp traffic. The unit opens a fixed observation window at the first member marker. It records when each member's marker lands inside that window. Once two windows in a row show the same relative arrival pattern, it reaches a verdict.

On success, every member channel is delayed through its own shift register by the gap between the latest arrival and its own arrival, so the markers leave the block in the same cycle. The status output then reports the total correction applied. If the measured spread is larger than the delay lines can absorb, the status reports an error code instead. In both cases the done flag rises. After a successful alignment, a monitor keeps comparing each member's output marker with the lowest-numbered member's output marker and latches any disagreement. A clear input returns the unit to its waiting state from any state.

Top module: `lane_deskew`

## Requirements
- R1: After reset, `eval_done`, `dsk_status`, `active_chans` and `monitor_err` are all zero, and every output lane equals its input lane in the same cycle.
- R2: The effective deskew set is `lane_member`, or `lane_member & 6'b010001` while `single_lane` is 1. Markers on channels outside that set affect neither the evaluation nor the active bits.
- R3: `active_chans[n]` becomes 1 in the cycle after a marker arrives on member channel n. It stays 1 until reset or until a cycle with `dsk_clear` high.
- R4: An evaluation window spans 8 cycles and starts with the first member marker, which has offset 0. A window is complete when every member has marked within it. A verdict is reached only at the close of a complete window whose member offsets equal those of the complete window just before it. Otherwise `eval_done` stays 0.
- R5: If the spread (latest minus earliest offset) is 5 or less, the verdict sets `eval_done` to 1 and `dsk_status` to the spread. That state then holds until cleared.
- R6: If the spread is 6 or 7, the verdict sets `eval_done` to 1 and `dsk_status` to 7. The value 6 never appears on `dsk_status`.
- R7: After a successful verdict, member channel n's marker and data leave delayed by (latest offset minus offset of n) cycles. Non-member channels, and all channels before a verdict or after an error verdict, pass with zero delay.
- R8: After a successful verdict, `monitor_err[n]` is set and held when member n's output marker differs from the output marker of the lowest-numbered member in the same cycle. The reference channel is never flagged.
- R9: A cycle with `dsk_clear` high returns the unit to waiting from any state. In the following cycle `eval_done`, `dsk_status`, `active_chans` and `monitor_err` read zero and all delays are zero.
- R10: With a marker period of at least 16 cycles, a member spread of 8 or more never completes a window, and `eval_done` stays 0.
- R11: While `eval_done` is 0, `dsk_status` and `monitor_err` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dsk_clear | input | 1 | Restart evaluation and clear all status |
| lane_member | input | 6 | Deskew set membership per channel |
| single_lane | input | 1 | Restrict the set to channels 0 and 4 |
| ch_data | input | 48 | Channel data, 8 bits per channel, channel 0 in the low bits |
| ch_mark | input | 6 | Marker flag per channel |
| out_data | output | 48 | Delayed channel data |
| out_mark | output | 6 | Delayed marker flags |
| eval_done | output | 1 | A verdict has been reached |
| dsk_status | output | 3 | Delay applied (0 to 5), or 7 for excessive skew |
| active_chans | output | 6 | Sticky marker-seen bits per member channel |
| monitor_err | output | 6 | Sticky misalignment bits after alignment |

## Verification
The assertions rely on the member mask and the single-lane select staying steady between clears. They also rely on markers on each member channel being spaced at least 16 cycles apart, so that one window never sees two markers from the same period. The stimulus changes the membership inputs only in the cycle it pulses `dsk_clear`. It spaces every channel's markers 32 cycles apart, with offsets inside one period, so each period produces at most one window attempt per spread pattern.

// File: rtl/lane_deskew_pkg.sv
package lane_deskew_pkg;

  localparam int unsigned STAT_W = 3;
  localparam logic [STAT_W-1:0] STAT_SKEW_ERR = 3'd7;

  typedef enum logic [1:0] {
    EV_WAIT    = 2'd0,
    EV_ALIGNED = 2'd1,
    EV_FAILED  = 2'd2
  } ev_state_e;

endpackage

// File: rtl/lane_deskew_dline.sv
module lane_deskew_dline #(
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned MAX_DLY = 5,
  parameter int unsigned DLY_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_mark,
  input  logic [DLY_W-1:0]  dly,
  output logic [DATA_W-1:0] out_data,
  output logic              out_mark
);

  localparam int unsigned SLOT_W = DATA_W + 1;

  logic [MAX_DLY-1:0][SLOT_W-1:0] sr_q;
  logic [MAX_DLY-1:0][SLOT_W-1:0] sr_d;
  logic [SLOT_W-1:0]              tap;
  logic                           shift_en;

  assign shift_en = 1'b1;

  // next-state of the shift chain
  always_comb begin
    sr_d[0] = {in_mark, in_data};
    for (int j = 1; j < int'(MAX_DLY); j++) begin
      sr_d[j] = sr_q[j-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (shift_en) begin
      sr_q <= sr_d;
    end
  end

  // tap select: zero delay taps the live input
  always_comb begin
    tap = {in_mark, in_data};
    for (int j = 0; j < int'(MAX_DLY); j++) begin
      if (int'(dly) == j + 1) tap = sr_q[j];
    end
  end

  assign out_mark = tap[SLOT_W-1];
  assign out_data = tap[DATA_W-1:0];

  AST_DLY_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(dly) <= int'(MAX_DLY))
    else $error("delay select beyond line depth"); // R5

endmodule

// File: rtl/lane_deskew_eval.sv
module lane_deskew_eval
  import lane_deskew_pkg::*;
#(
  parameter int unsigned NUM_CH  = 6,
  parameter int unsigned WIN_LEN = 8,
  parameter int unsigned MAX_DLY = 5,
  parameter int unsigned DLY_W   = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic [NUM_CH-1:0]       member,
  input  logic [NUM_CH-1:0]       mark_in,
  output ev_state_e               state_o,
  output logic [STAT_W-1:0]       status_o,
  output logic [NUM_CH*DLY_W-1:0] dly_o
);

  localparam int unsigned OFF_W = $clog2(WIN_LEN);
  localparam logic [OFF_W-1:0] LAST_POS = OFF_W'(WIN_LEN - 1);

  ev_state_e                      state_q, state_d;
  logic                           win_open_q, win_open_d;
  logic [OFF_W-1:0]               win_cnt_q, win_cnt_d;
  logic [NUM_CH-1:0]              seen_q, seen_d;
  logic [NUM_CH-1:0][OFF_W-1:0]   off_q, off_d;
  logic [NUM_CH-1:0][OFF_W-1:0]   prev_off_q, prev_off_d;
  logic                           prev_vld_q, prev_vld_d;
  logic [NUM_CH-1:0][DLY_W-1:0]   dly_q, dly_d;
  logic [DLY_W-1:0]               skew_q, skew_d;

  logic [NUM_CH-1:0]              mem_marks;
  logic                           open_now;
  logic [OFF_W-1:0]               pos;
  logic [NUM_CH-1:0]              cur_seen;
  logic [NUM_CH-1:0][OFF_W-1:0]   cur_off;
  logic                           closing;
  logic                           complete;
  logic                           same_shape;
  logic [OFF_W-1:0]               max_off;
  logic                           fits;

  // window tracking
  assign mem_marks = mark_in & member;
  assign open_now  = (state_q == EV_WAIT) && !win_open_q && (|mem_marks);
  assign pos       = win_open_q ? win_cnt_q : '0;
  assign cur_seen  = (win_open_q ? seen_q : '0) | mem_marks;
  assign closing   = (win_open_q || open_now) && (pos == LAST_POS);
  assign complete  = closing && (cur_seen == member);

  always_comb begin
    for (int i = 0; i < int'(NUM_CH); i++) begin
      cur_off[i] = (win_open_q && seen_q[i]) ? off_q[i] : pos;
    end
  end

  always_comb begin
    max_off    = '0;
    same_shape = 1'b1;
    for (int i = 0; i < int'(NUM_CH); i++) begin
      if (member[i]) begin
        if (cur_off[i] > max_off) max_off = cur_off[i];
        if (cur_off[i] != prev_off_q[i]) same_shape = 1'b0;
      end
    end
  end

  assign fits = int'(max_off) <= int'(MAX_DLY);

  // next-state
  always_comb begin
    state_d    = state_q;
    win_open_d = win_open_q;
    win_cnt_d  = win_cnt_q;
    seen_d     = seen_q;
    off_d      = off_q;
    prev_off_d = prev_off_q;
    prev_vld_d = prev_vld_q;
    dly_d      = dly_q;
    skew_d     = skew_q;
    if (clr) begin
      state_d    = EV_WAIT;
      win_open_d = 1'b0;
      win_cnt_d  = '0;
      seen_d     = '0;
      off_d      = '0;
      prev_off_d = '0;
      prev_vld_d = 1'b0;
      dly_d      = '0;
      skew_d     = '0;
    end else if (state_q == EV_WAIT && (win_open_q || open_now)) begin
      if (closing) begin
        win_open_d = 1'b0;
        win_cnt_d  = '0;
        seen_d     = '0;
        if (complete && prev_vld_q && same_shape) begin
          prev_vld_d = 1'b0;
          if (fits) begin
            state_d = EV_ALIGNED;
            skew_d  = DLY_W'(max_off);
            for (int i = 0; i < int'(NUM_CH); i++) begin
              dly_d[i] = member[i] ? DLY_W'(max_off - cur_off[i]) : '0;
            end
          end else begin
            state_d = EV_FAILED;
          end
        end else if (complete) begin
          prev_off_d = cur_off;
          prev_vld_d = 1'b1;
        end else begin
          prev_vld_d = 1'b0;
        end
      end else begin
        win_open_d = 1'b1;
        win_cnt_d  = pos + OFF_W'(1);
        seen_d     = cur_seen;
        off_d      = cur_off;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= EV_WAIT;
      win_open_q <= 1'b0;
      win_cnt_q  <= '0;
      seen_q     <= '0;
      off_q      <= '0;
      prev_off_q <= '0;
      prev_vld_q <= 1'b0;
      dly_q      <= '0;
      skew_q     <= '0;
    end else begin
      state_q    <= state_d;
      win_open_q <= win_open_d;
      win_cnt_q  <= win_cnt_d;
      seen_q     <= seen_d;
      off_q      <= off_d;
      prev_off_q <= prev_off_d;
      prev_vld_q <= prev_vld_d;
      dly_q      <= dly_d;
      skew_q     <= skew_d;
    end
  end

  always_comb begin
    case (state_q)
      EV_ALIGNED: status_o = STAT_W'(skew_q);
      EV_FAILED:  status_o = STAT_SKEW_ERR;
      default:    status_o = '0;
    endcase
  end

  assign state_o = state_q;
  assign dly_o   = dly_q;

  AST_VERDICT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != EV_WAIT && !clr) |=> state_q == $past(state_q))
    else $error("verdict changed without clear"); // R5

  AST_NO_DELAY_UNLESS_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != EV_ALIGNED) |-> (dly_q == '0))
    else $error("delay applied outside aligned state"); // R7

endmodule

// File: rtl/lane_deskew_mon.sv
module lane_deskew_mon #(
  parameter int unsigned NUM_CH = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              enable,
  input  logic [NUM_CH-1:0] member,
  input  logic [NUM_CH-1:0] mark_out,
  output logic [NUM_CH-1:0] err
);

  logic [NUM_CH-1:0] ref_hot;
  logic              ref_found;
  logic              ref_mark;
  logic [NUM_CH-1:0] mismatch;
  logic [NUM_CH-1:0] err_q, err_d;

  // lowest-numbered member is the reference
  always_comb begin
    ref_hot   = '0;
    ref_found = 1'b0;
    for (int i = 0; i < int'(NUM_CH); i++) begin
      if (member[i] && !ref_found) begin
        ref_hot[i] = 1'b1;
        ref_found  = 1'b1;
      end
    end
  end

  assign ref_mark = |(mark_out & ref_hot);
  assign mismatch = member & (mark_out ^ {NUM_CH{ref_mark}});

  always_comb begin
    err_d = err_q;
    if (clr) begin
      err_d = '0;
    end else if (enable) begin
      err_d = err_q | mismatch;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= '0;
    end else begin
      err_q <= err_d;
    end
  end

  assign err = err_q;

  AST_MON_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (!enable && !clr) |=> $stable(err_q))
    else $error("monitor bits moved while monitor disabled"); // R8

  AST_MON_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(err_q) & ~err_q)) |-> $past(clr))
    else $error("monitor bit dropped without clear"); // R8

endmodule

// File: rtl/lane_deskew.sv
module lane_deskew
  import lane_deskew_pkg::*;
#(
  parameter int unsigned       NUM_CH  = 6,
  parameter int unsigned       DATA_W  = 8,
  parameter int unsigned       MAX_DLY = 5,
  parameter int unsigned       WIN_LEN = 8,
  parameter logic [NUM_CH-1:0] SL_MASK = 6'b010001
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     dsk_clear,
  input  logic [NUM_CH-1:0]        lane_member,
  input  logic                     single_lane,
  input  logic [NUM_CH*DATA_W-1:0] ch_data,
  input  logic [NUM_CH-1:0]        ch_mark,
  output logic [NUM_CH*DATA_W-1:0] out_data,
  output logic [NUM_CH-1:0]        out_mark,
  output logic                     eval_done,
  output logic [STAT_W-1:0]        dsk_status,
  output logic [NUM_CH-1:0]        active_chans,
  output logic [NUM_CH-1:0]        monitor_err
);

  localparam int unsigned DLY_W = $clog2(MAX_DLY + 1);

  logic [NUM_CH-1:0]       eff_member;
  ev_state_e               ev_state;
  logic [NUM_CH*DLY_W-1:0] dly_flat;
  logic [NUM_CH-1:0]       active_q, active_d;

  assign eff_member = single_lane ? (lane_member & SL_MASK) : lane_member;

  // sticky marker-seen bits
  always_comb begin
    active_d = active_q;
    if (dsk_clear) begin
      active_d = '0;
    end else begin
      active_d = active_q | (ch_mark & eff_member);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= '0;
    end else begin
      active_q <= active_d;
    end
  end

  lane_deskew_eval #(
    .NUM_CH (NUM_CH),
    .WIN_LEN(WIN_LEN),
    .MAX_DLY(MAX_DLY),
    .DLY_W  (DLY_W)
  ) eval_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (dsk_clear),
    .member  (eff_member),
    .mark_in (ch_mark),
    .state_o (ev_state),
    .status_o(dsk_status),
    .dly_o   (dly_flat)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_lane
    lane_deskew_dline #(
      .DATA_W (DATA_W),
      .MAX_DLY(MAX_DLY),
      .DLY_W  (DLY_W)
    ) dline_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_data (ch_data[g*DATA_W +: DATA_W]),
      .in_mark (ch_mark[g]),
      .dly     (dly_flat[g*DLY_W +: DLY_W]),
      .out_data(out_data[g*DATA_W +: DATA_W]),
      .out_mark(out_mark[g])
    );
  end

  lane_deskew_mon #(
    .NUM_CH(NUM_CH)
  ) mon_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (dsk_clear),
    .enable  (ev_state == EV_ALIGNED),
    .member  (eff_member),
    .mark_out(out_mark),
    .err     (monitor_err)
  );

  assign eval_done    = (ev_state != EV_WAIT);
  assign active_chans = active_q;

  AST_STATUS_NOT_SIX: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_status != 3'd6)
    else $error("reserved status code produced"); // R6

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_done |-> (dsk_status == '0 && monitor_err == '0))
    else $error("status visible before verdict"); // R11

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_done && !dsk_clear) |=> eval_done)
    else $error("done flag dropped without clear"); // R5

  AST_CLEAR_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    dsk_clear |=> (!eval_done && active_chans == '0 && monitor_err == '0))
    else $error("clear did not restart"); // R9

  AST_ACTIVE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (|($past(active_chans) & ~active_chans)) |-> $past(dsk_clear))
    else $error("active bit dropped without clear"); // R3

endmodule

// File: tb/lane_deskew_tb.sv
module lane_deskew_tb_top;

  localparam int NCH  = 6;
  localparam int DW   = 8;
  localparam int PER  = 32;

  typedef struct packed {
    logic [5:0]  mask;
    logic        sl;
    logic [23:0] offs;
    logic        done;
    logic [2:0]  stat;
  } vec_t;

  // offs holds channel n in bits [4n+3:4n]
  localparam vec_t VEC [8] = '{
    '{6'h3F, 1'b0, 24'h000000, 1'b1, 3'd0},
    '{6'h3F, 1'b0, 24'h543210, 1'b1, 3'd5},
    '{6'h0F, 1'b0, 24'hFF2413, 1'b1, 3'd3},
    '{6'h3F, 1'b0, 24'h000060, 1'b1, 3'd7},
    '{6'h21, 1'b0, 24'h000007, 1'b1, 3'd7},
    '{6'h3F, 1'b1, 24'h959992, 1'b1, 3'd3},
    '{6'h03, 1'b0, 24'h000090, 1'b0, 3'd0},
    '{6'h3F, 1'b0, 24'h444444, 1'b1, 3'd0}
  };

  logic             clk;
  logic             rst_n;
  logic             dsk_clear;
  logic [NCH-1:0]   lane_member;
  logic             single_lane;
  logic [NCH*DW-1:0] ch_data;
  logic [NCH-1:0]   ch_mark;
  logic [NCH*DW-1:0] out_data;
  logic [NCH-1:0]   out_mark;
  logic             eval_done;
  logic [2:0]       dsk_status;
  logic [NCH-1:0]   active_chans;
  logic [NCH-1:0]   monitor_err;

  int n_chk = 0;
  int n_err = 0;
  int k = 0;
  int v_dly [NCH];
  int v_pos [NCH];

  lane_deskew dut_i (
    .clk(clk), .rst_n(rst_n), .dsk_clear(dsk_clear),
    .lane_member(lane_member), .single_lane(single_lane),
    .ch_data(ch_data), .ch_mark(ch_mark),
    .out_data(out_data), .out_mark(out_mark),
    .eval_done(eval_done), .dsk_status(dsk_status),
    .active_chans(active_chans), .monitor_err(monitor_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    dsk_clear = 1'b1;
    ch_mark   = '0;
    @(negedge clk);
    dsk_clear = 1'b0;
    #1;
  endtask

  task automatic set_expect(input logic [5:0] eff, input logic [23:0] offs,
                            input bit aligned);
    int maxo;
    maxo = 0;
    for (int i = 0; i < NCH; i++)
      if (eff[i] && int'(offs[4*i +: 4]) > maxo) maxo = int'(offs[4*i +: 4]);
    for (int i = 0; i < NCH; i++) begin
      v_dly[i] = (aligned && eff[i]) ? maxo - int'(offs[4*i +: 4]) : 0;
      v_pos[i] = int'(offs[4*i +: 4]) + v_dly[i];
    end
  endtask

  // one marker period; chk compares outputs against v_dly / v_pos
  task automatic drive_period(input logic [23:0] offs, input bit chk);
    bit bad [NCH];
    for (int i = 0; i < NCH; i++) bad[i] = 1'b0;
    for (int p = 0; p < PER; p++) begin
      @(negedge clk);
      k++;
      for (int i = 0; i < NCH; i++) begin
        ch_mark[i] = (p == int'(offs[4*i +: 4]));
        ch_data[i*DW +: DW] = DW'(k + 16*i);
      end
      #1;
      if (chk) begin
        for (int i = 0; i < NCH; i++) begin
          if (out_mark[i] !== (p == v_pos[i])) bad[i] = 1'b1;
          if (p == v_pos[i] && out_data[i*DW +: DW] !== DW'(k - v_dly[i] + 16*i))
            bad[i] = 1'b1;
        end
      end
    end
    if (chk)
      for (int i = 0; i < NCH; i++)
        check(!bad[i], "R7", $sformatf("lane %0d timing, mismatch flag", i),
              int'(bad[i]), 0);
  endtask

  initial begin
    #(200000 * 10);
    n_err++;
    n_chk++;
    $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [5:0] eff;
    rst_n = 1'b0;
    dsk_clear = 1'b0;
    lane_member = 6'h3F;
    single_lane = 1'b0;
    ch_data = '0;
    ch_mark = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    check(eval_done == 1'b0, "R1", "eval_done", int'(eval_done), 0);
    check(dsk_status == 3'd0, "R1", "status", int'(dsk_status), 0);
    check(active_chans == '0, "R1", "active", int'(active_chans), 0);
    check(monitor_err == '0, "R1", "monitor", int'(monitor_err), 0);
    set_expect(6'h3F, 24'h000000, 1'b0);
    set_expect(6'h3F, 24'h012345, 1'b0);
    drive_period(24'h012345, 1'b1); // R1 pass-through before verdict

    // table walk
    for (int v = 0; v < 8; v++) begin
      @(negedge clk);
      lane_member = VEC[v].mask;
      single_lane = VEC[v].sl;
      pulse_clear();
      check(!eval_done && active_chans == '0, "R9", $sformatf("vec %0d clear", v),
            int'(eval_done), 0);
      eff = VEC[v].sl ? (VEC[v].mask & 6'h11) : VEC[v].mask;
      drive_period(VEC[v].offs, 1'b0);
      drive_period(VEC[v].offs, 1'b0);
      check(eval_done == VEC[v].done, "R4 R5 R10", $sformatf("vec %0d done", v),
            int'(eval_done), int'(VEC[v].done));
      check(dsk_status == VEC[v].stat, "R5 R6 R11", $sformatf("vec %0d status", v),
            int'(dsk_status), int'(VEC[v].stat));
      check(active_chans == eff, "R2 R3", $sformatf("vec %0d active", v),
            int'(active_chans), int'(eff));
      set_expect(eff, VEC[v].offs, VEC[v].done && VEC[v].stat < 3'd6);
      drive_period(VEC[v].offs, 1'b1);
      check(monitor_err == '0, "R8", $sformatf("vec %0d monitor", v),
            int'(monitor_err), 0);
    end

    // R4: differing shapes delay the verdict
    @(negedge clk);
    lane_member = 6'h3F;
    single_lane = 1'b0;
    pulse_clear();
    drive_period(24'h000010, 1'b0);
    drive_period(24'h000020, 1'b0);
    check(eval_done == 1'b0, "R4", "shape change keeps waiting", int'(eval_done), 0);
    drive_period(24'h000020, 1'b0);
    check(eval_done == 1'b1, "R4", "matching shape concludes", int'(eval_done), 1);
    check(dsk_status == 3'd2, "R5", "status after reshape", int'(dsk_status), 2);

    // R8: late marker after alignment flags only that lane
    @(negedge clk);
    lane_member = 6'h0F;
    pulse_clear();
    drive_period(24'h000000, 1'b0);
    drive_period(24'h000000, 1'b0);
    check(eval_done && dsk_status == 3'd0, "R5", "aligned zero skew",
          int'(dsk_status), 0);
    drive_period(24'h000100, 1'b0);
    check(monitor_err == 6'h04, "R8", "monitor flags lane 2",
          int'(monitor_err), 4);
    check(eval_done == 1'b1, "R5", "done holds after drift", int'(eval_done), 1);

    // R9: clear wipes all status
    pulse_clear();
    check(eval_done == 1'b0, "R9", "done after clear", int'(eval_done), 0);
    check(dsk_status == 3'd0, "R9", "status after clear", int'(dsk_status), 0);
    check(monitor_err == '0, "R9", "monitor after clear", int'(monitor_err), 0);
    check(active_chans == '0, "R9", "active after clear", int'(active_chans), 0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule